// File: doc/BRIEF.md
# Shift-Cascade Traceback Survivor Unit

This block is the survivor path store and traceback engine for a 4-state (constraint length 3) Viterbi decoder. Each clock cycle in which the add-compare-select array offers a decision vector, the block takes it in. The vector holds one bit per trellis state. The block returns one decoded bit for that step. Traceback runs in a cascade of identical cells, and each cell moves the trace back by one trellis stage. Decision vectors flow down a delay line of two registers per cell. A traced-state pointer flows down the same cascade, one cell per step. Each cell therefore meets exactly the older decision vector it needs. No reversal buffer, RAM or address sequencer is needed.

Each trace starts from a fixed state chosen by parameter (state 0 by default), not from the state with the best path metric. Depth is a parameter (default 15 cells, about five constraint lengths). This is deep enough that traces started from any state merge onto the survivor path before they reach the last cell. The decoded bit is the most significant bit of the pointer in the last cell.

Top module: `traceback_survivor`

## Requirements
- R1: While `rst` is high, and in the cycle that follows it, `bit_valid` is 0 and `bit_out` is 0.
- R2: `bit_valid` is high for exactly the cycle after an accepted step (`dec_valid` high at a rising edge), once at least 2*DEPTH-1 steps have been accepted since reset, counting that one. It is never high earlier.
- R3: In the cycle after an edge where `dec_valid` was low, `bit_valid` is 0.
- R4: Trace rule: bit s of `dec_vec` is the decision for state number s. From state s, one traceback stage moves to state {s[0], dec_vec[s]}. That is, the decision bit is shifted in as the new LSB and the old MSB is dropped.
- R5: After accepted step n (0-based), `bit_out` is the MSB of the state reached by starting at state START_STATE and applying the R4 rule with the vectors of steps n-DEPTH+1, n-DEPTH, ... down to n-2*DEPTH+2, in that order.
- R6: Cycles with `dec_valid` low are ignored by the trace. Inserting such cycles anywhere in a stream leaves the sequence of valid decoded bits unchanged.
- R7: If the vector of step n has all bits equal to the encoder input of step n-2, the trace converges from the arbitrary start state. The valid `bit_out` after step n then equals the encoder input of step n-2*DEPTH+1, with inputs before step 0 taken as 0.
- R8: `bit_out` holds its value through any cycle that follows an edge where `dec_valid` was low.
- R9: A reset in the middle of a stream discards all stored decisions, and the R2 fill count starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| dec_valid | input | 1 | Decision vector present this cycle; the cascade advances only when high |
| dec_vec | input | 4 | Survivor decisions, bit s belonging to state s |
| bit_valid | output | 1 | Decoded bit valid for the step accepted on the previous edge |
| bit_out | output | 1 | Decoded bit |

## Verification
Every result is registered on the same edge that accepts a step, so both `bit_valid` and `bit_out` are due one clock after that edge. The first valid bit follows the (2*DEPTH-1)th accepted step. The bench drives inputs on the falling edge and samples 1 ns after the next rising edge. This puts each comparison exactly one register stage after its stimulus. It keeps a step-indexed history of vectors, so stalls shift no expectation. Expected bits come from an arithmetic trace over that history, and in the convergent stream also from the encoder bits delayed by 2*DEPTH-1 steps.

// File: rtl/tbk_pkg.sv
package tbk_pkg;

    localparam int STATE_W    = 2;
    localparam int NUM_STATES = 1 << STATE_W;

    typedef logic [STATE_W-1:0]    state_t;
    typedef logic [NUM_STATES-1:0] dvec_t;

    // decision vector travelling down the delay line
    typedef struct packed {
        logic  vld;
        dvec_t bits;
    } dslot_t;

    // traced state travelling down the cascade
    typedef struct packed {
        logic   vld;
        state_t st;
    } ptr_t;

    // one traceback stage: decision bit enters as LSB, MSB falls off
    function automatic state_t pred_state(input state_t s, input dvec_t d);
        state_t r;
        r = {s[STATE_W-2:0], d[s]};
        return r;
    endfunction

endpackage

// File: rtl/tbk_dec_pair.sv
module tbk_dec_pair
    import tbk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   adv,
    input  dslot_t dec_in,
    output dslot_t dec_fwd
);

    dslot_t stage_a;
    dslot_t stage_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_a <= '0;
            stage_b <= '0;
        end else if (adv) begin
            stage_a <= dec_in;
            stage_b <= stage_a;
        end
    end

    assign dec_fwd = stage_b;

endmodule

// File: rtl/tbk_cell.sv
module tbk_cell
    import tbk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   adv,
    input  dslot_t dec_in,
    input  ptr_t   ptr_in,
    output ptr_t   ptr_q
);

    ptr_t ptr_nxt;

    always_comb begin
        ptr_nxt.vld = ptr_in.vld & dec_in.vld;
        ptr_nxt.st  = pred_state(ptr_in.st, dec_in.bits);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (adv) begin
            ptr_q <= ptr_nxt;
        end
    end

endmodule

// File: rtl/tbk_out_stage.sv
module tbk_out_stage
    import tbk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  ptr_t ptr_last,
    output logic bit_valid,
    output logic bit_out
);

    logic adv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            adv_q <= 1'b0;
        end else begin
            adv_q <= adv;
        end
    end

    assign bit_valid = adv_q & ptr_last.vld;
    assign bit_out   = ptr_last.st[STATE_W-1];

endmodule

// File: rtl/traceback_survivor.sv
module traceback_survivor
    import tbk_pkg::*;
#(
    parameter int DEPTH       = 15,
    parameter int START_STATE = 0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  dec_valid,
    input  logic [NUM_STATES-1:0] dec_vec,
    output logic                  bit_valid,
    output logic                  bit_out
);

    localparam int     LAST      = DEPTH - 1;
    localparam state_t START_ST  = state_t'(START_STATE);

    ptr_t   ptr_chain [DEPTH+1];
    dslot_t dec_chain [DEPTH];

    assign ptr_chain[0].vld  = 1'b1;
    assign ptr_chain[0].st   = START_ST;
    assign dec_chain[0].vld  = dec_valid;
    assign dec_chain[0].bits = dec_vec;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        tbk_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .adv    (dec_valid),
            .dec_in (dec_chain[g]),
            .ptr_in (ptr_chain[g]),
            .ptr_q  (ptr_chain[g+1])
        );
        if (g < LAST) begin : g_fwd
            tbk_dec_pair u_pair (
                .clk     (clk),
                .rst     (rst),
                .adv     (dec_valid),
                .dec_in  (dec_chain[g]),
                .dec_fwd (dec_chain[g+1])
            );
        end
    end

    tbk_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .adv       (dec_valid),
        .ptr_last  (ptr_chain[DEPTH]),
        .bit_valid (bit_valid),
        .bit_out   (bit_out)
    );

endmodule

// File: rtl/tbk_checker.sv
module tbk_checker #(
    parameter int DEPTH = 15
) (
    input logic clk,
    input logic rst,
    input logic dec_valid,
    input logic bit_valid,
    input logic bit_out
);

    localparam int FILL = 2 * DEPTH - 1;

    int seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= 0;
        end else if (dec_valid && seen < FILL) begin
            seen <= seen + 1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!bit_valid && !bit_out));

    // R2
    early_valid_chk: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> (seen >= FILL));

    // R2
    filled_valid_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(dec_valid) && !$past(rst) && seen >= FILL) |-> bit_valid);

    // R3
    stall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(dec_valid) |-> !bit_valid);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(dec_valid) && !$past(rst)) |-> $stable(bit_out));

endmodule

bind traceback_survivor tbk_checker #(.DEPTH(DEPTH)) u_tbk_checker (
    .clk       (clk),
    .rst       (rst),
    .dec_valid (dec_valid),
    .bit_valid (bit_valid),
    .bit_out   (bit_out)
);

// File: tb/test_traceback_survivor.sv
module test_traceback_survivor;

    localparam int D = 15;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dec_valid = 1'b0;
    logic [3:0] dec_vec = 4'h0;
    logic       bit_valid;
    logic       bit_out;

    int checks = 0;
    int errors = 0;
    int cnt = 0;
    logic last_out = 1'b0;
    logic [3:0] hist [0:1023];
    logic       uu   [0:1023];

    always #5 clk = ~clk;

    traceback_survivor #(.DEPTH(D), .START_STATE(0)) i_traceback_survivor (
        .clk       (clk),
        .rst       (rst),
        .dec_valid (dec_valid),
        .dec_vec   (dec_vec),
        .bit_valid (bit_valid),
        .bit_out   (bit_out)
    );

    task automatic check_eq(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b (time %0t)", req, act, exp, $time);
        end
    endtask

    // trace per R4/R5 over the recorded history, start state 0
    function automatic logic model_bit(input int n);
        logic [1:0] p;
        p = 2'd0;
        for (int k = n - D + 1; k >= n - 2*D + 2; k--) begin
            p = {p[0], hist[k][p]};
        end
        return p[1];
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        dec_valid = 1'b0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        check_eq("R1 valid in reset", bit_valid, 1'b0);
        check_eq("R1 bit in reset", bit_out, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        check_eq("R1 valid after reset", bit_valid, 1'b0);
        check_eq("R1 bit after reset", bit_out, 1'b0);
        cnt = 0;
        last_out = bit_out;
    endtask

    task automatic step(input logic v, input logic [3:0] vec, input string tag);
        int  n;
        logic ev;
        @(negedge clk);
        dec_valid = v;
        dec_vec   = vec;
        @(posedge clk); #1;
        if (v) begin
            hist[cnt] = vec;
            n = cnt;
            cnt++;
            ev = (n >= 2*D - 2);
            check_eq({tag, " R2 valid timing"}, bit_valid, ev);
            if (ev) check_eq({tag, " R5 traced bit"}, bit_out, model_bit(n));
        end else begin
            check_eq({tag, " R3 no valid on stall"}, bit_valid, 1'b0);
            check_eq({tag, " R8 hold on stall"}, bit_out, last_out);
        end
        last_out = bit_out;
    endtask

    initial begin
        #100us;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();

        // R7: convergent stream, decisions follow the encoder input two steps back
        for (int n = 0; n < 90; n++) begin
            logic ub;
            uu[n] = 1'($urandom_range(0, 1));
            ub = (n >= 2) ? uu[n-2] : 1'b0;
            step(1'b1, {4{ub}}, "conv");
            if (n >= 2*D - 2) begin
                check_eq("R7 converged bit", bit_out, (n - 2*D + 1 >= 0) ? uu[n-2*D+1] : 1'b0);
            end
        end

        // R4: sweep every constant decision vector
        for (int v = 0; v < 16; v++) begin
            do_reset();
            for (int n = 0; n < 2*D + 3; n++) step(1'b1, 4'(v), "R4 sweep");
        end

        // R5: random decision vectors, no gaps
        do_reset();
        for (int n = 0; n < 120; n++) step(1'b1, 4'($urandom_range(0, 15)), "R5 random");

        // R6: random vectors with random stalls
        do_reset();
        for (int n = 0; n < 200; n++) begin
            if ($urandom_range(0, 2) == 0) step(1'b0, 4'($urandom_range(0, 15)), "R6 gap");
            else step(1'b1, 4'($urandom_range(0, 15)), "R6 gapped");
        end

        // R9: reset mid-stream, then refill
        for (int n = 0; n < 10; n++) step(1'b1, 4'($urandom_range(0, 15)), "R9 pre");
        do_reset();
        for (int n = 0; n < 2*D + 5; n++) step(1'b1, 4'($urandom_range(0, 15)), "R9 refill");

        @(negedge clk);
        dec_valid = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule